// File: doc/BRIEF.md
# Atomic Lock and Semaphore Unit

A memory-side synchronisation unit shared by several requesters. It holds a small bank of words used as lock flags and as counting semaphores. Each requester drives a request (valid, opcode, word address, operand) and holds it until the unit grants it. A granted operation reads the addressed word, computes the new value and writes it back in the same clock cycle. The read and the write therefore form one indivisible step, and no other requester can act on the word between them.

One cycle after the grant, the unit returns the word's prior value on a shared response bus, together with a failure flag. Locks use the swap-to-one operation to acquire and a plain store of zero to release. Semaphores are set up by a store of the holder count N. The decrement-if-positive operation takes a slot and returns failure when the count is zero, so the requester retries rather than blocking. The increment operation returns a slot. A separate load followed by a store gives no atomicity: two requesters can both read a lock as free.

Top module: `atomic_sync_unit`

## Requirements
- R1: At most one requester is granted per cycle, and only one whose valid is high. The response (one-hot `rsp_valid`, `rsp_old`, `rsp_fail`) appears exactly one cycle after the grant, and only for the granted requester.
- R2: Opcode 0 (load) returns the word and leaves it unchanged.
- R3: Opcode 1 (store) writes the operand and returns the prior value. The written value is the one seen by the next access.
- R4: Opcode 2 (test-and-set) returns the prior value and leaves the word at 1. A free (0) lock is acquired, and a busy (1) lock stays at 1.
- R5: When two requesters issue test-and-set to the same free word in the same cycle, exactly one of them receives 0 and the other receives 1.
- R6: Opcode 3 (fetch-and-add) returns the prior value and stores the prior value plus the operand, modulo 2^DATA_W.
- R7: Opcode 4 (semaphore wait) on a non-zero word returns it and decrements it, with `rsp_fail` low. On a zero word it leaves the word at 0 and returns it with `rsp_fail` high.
- R8: Opcode 5 (semaphore signal) returns the prior value and stores the prior value plus one.
- R9: Grants rotate round-robin, and the search starts at the requester after the last winner. A requester holding valid is granted within NUM_REQ cycles.
- R10: Reset clears every word to 0. While reset is asserted there is no grant and no response.
- R11: Opcodes 6 and 7 behave as a load: the word is unchanged and `rsp_fail` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Request pending, one bit per requester |
| req_op | input | NUM_REQ*3 | Opcode per requester |
| req_addr | input | NUM_REQ*ADDR_W | Word address per requester |
| req_data | input | NUM_REQ*DATA_W | Operand per requester |
| req_grant | output | NUM_REQ | One-hot grant; the operation executes in this cycle |
| rsp_valid | output | NUM_REQ | One-hot response strobe, one cycle after the grant |
| rsp_old | output | DATA_W | Prior value of the addressed word |
| rsp_fail | output | 1 | Semaphore wait found a zero count |

## Verification
A corrupted word shows up as a wrong `rsp_old` at the next access to that address. That is one cycle after the grant of the following operation on the word. A stale round-robin pointer shows up as a grant order that departs from the rotation in the first cycle two or more requesters compete. A wrong decision in the read-modify-write path appears either as a wrong value returned to the second contender for a free lock, or as a wrong `rsp_fail` in the response cycle of a wait on an empty semaphore.

// File: rtl/sync_pkg.sv
package sync_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_LOAD   = 3'd0;
  localparam logic [OP_W-1:0] OP_STORE  = 3'd1;
  localparam logic [OP_W-1:0] OP_TAS    = 3'd2;
  localparam logic [OP_W-1:0] OP_FADD   = 3'd3;
  localparam logic [OP_W-1:0] OP_WAIT   = 3'd4;
  localparam logic [OP_W-1:0] OP_SIGNAL = 3'd5;
endpackage

// File: rtl/sync_rr_arbiter.sv
module sync_rr_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int REQ_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] valid,
  output logic [NUM_REQ-1:0] grant,
  output logic [REQ_W-1:0]   win_idx,
  output logic               any_grant
);
  logic [REQ_W-1:0] ptr_q;

  // rotating priority search starting at ptr_q
  always_comb begin
    logic found;
    found   = 1'b0;
    grant   = '0;
    win_idx = '0;
    for (int k = 0; k < NUM_REQ; k++) begin
      int cand;
      cand = (int'(ptr_q) + k) % NUM_REQ;
      if (!found && rst_n && valid[cand]) begin
        found       = 1'b1;
        grant[cand] = 1'b1;
        win_idx     = REQ_W'(cand);
      end
    end
    any_grant = found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (any_grant) begin
      ptr_q <= (win_idx == REQ_W'(NUM_REQ - 1)) ? '0 : win_idx + 1'b1;
    end
  end

  // per-requester wait counters, brought out for the starvation bound
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_wait
    logic [REQ_W:0] wait_cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wait_cnt <= '0;
      end else if (valid[i] && !grant[i]) begin
        wait_cnt <= wait_cnt + 1'b1;
      end else begin
        wait_cnt <= '0;
      end
    end

    assert_no_starvation_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt < (REQ_W+1)'(NUM_REQ))
      else $error("requester %0d waited too long", i);
  end
endmodule

// File: rtl/sync_word_bank.sv
module sync_word_bank #(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 16,
  localparam int ADDR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [NUM_WORDS];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) mem[w] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assert_write_lands_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data))
    else $error("word write lost");
endmodule

// File: rtl/sync_rmw_exec.sv
module sync_rmw_exec
  import sync_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] new_val,
  output logic              do_write,
  output logic              fail
);
  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  always_comb begin
    new_val  = old_val;
    do_write = 1'b0;
    fail     = 1'b0;
    unique case (op)
      OP_STORE: begin
        new_val  = operand;
        do_write = 1'b1;
      end
      OP_TAS: begin
        new_val  = DATA_W'(1);
        do_write = 1'b1;
      end
      OP_FADD: begin
        new_val  = add_wrap(old_val, operand);
        do_write = 1'b1;
      end
      OP_WAIT: begin
        if (old_val == '0) begin
          fail = 1'b1;
        end else begin
          new_val  = add_wrap(old_val, '1);
          do_write = 1'b1;
        end
      end
      OP_SIGNAL: begin
        new_val  = add_wrap(old_val, DATA_W'(1));
        do_write = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/atomic_sync_unit.sv
module atomic_sync_unit
  import sync_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 16,
  localparam int ADDR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req_valid,
  input  logic [NUM_REQ*OP_W-1:0]   req_op,
  input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
  input  logic [NUM_REQ*DATA_W-1:0] req_data,
  output logic [NUM_REQ-1:0]        req_grant,
  output logic [NUM_REQ-1:0]        rsp_valid,
  output logic [DATA_W-1:0]         rsp_old,
  output logic                      rsp_fail
);
  logic [NUM_REQ-1:0] grant;
  logic [REQ_W-1:0]   win_idx;
  logic               fire;

  logic [OP_W-1:0]    sel_op;
  logic [ADDR_W-1:0]  sel_addr;
  logic [DATA_W-1:0]  sel_data;

  logic [DATA_W-1:0]  old_word;
  logic [DATA_W-1:0]  new_word;
  logic               exec_write;
  logic               exec_fail;
  logic               wr_en;

  logic [NUM_REQ-1:0] rsp_valid_q;
  logic [DATA_W-1:0]  rsp_old_q;
  logic               rsp_fail_q;

  sync_rr_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (req_valid),
    .grant     (grant),
    .win_idx   (win_idx),
    .any_grant (fire)
  );

  // winner's request fields
  assign sel_op   = req_op[win_idx*OP_W +: OP_W];
  assign sel_addr = req_addr[win_idx*ADDR_W +: ADDR_W];
  assign sel_data = req_data[win_idx*DATA_W +: DATA_W];

  sync_word_bank #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (sel_addr),
    .rd_data (old_word),
    .wr_en   (wr_en),
    .wr_addr (sel_addr),
    .wr_data (new_word)
  );

  sync_rmw_exec #(.DATA_W(DATA_W)) u_exec (
    .op       (sel_op),
    .old_val  (old_word),
    .operand  (sel_data),
    .new_val  (new_word),
    .do_write (exec_write),
    .fail     (exec_fail)
  );

  // read and write of the word happen in the one granted cycle
  assign wr_en = fire & exec_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= '0;
      rsp_old_q   <= '0;
      rsp_fail_q  <= 1'b0;
    end else begin
      rsp_valid_q <= grant;
      rsp_fail_q  <= fire & exec_fail;
      if (fire) rsp_old_q <= old_word;
    end
  end

  assign req_grant = grant;
  assign rsp_valid = rsp_valid_q;
  assign rsp_old   = rsp_old_q;
  assign rsp_fail  = rsp_fail_q;

  assert_one_grant_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req_valid) == '0))
    else $error("illegal grant");

  assert_rsp_tracks_grant_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(grant))
    else $error("response not one cycle after grant");

  assert_tas_sets_word_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == OP_TAS) |-> (wr_en && new_word == DATA_W'(1)))
    else $error("test-and-set did not write 1");

  assert_wait_empty_no_write_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == OP_WAIT && old_word == '0) |-> !wr_en)
    else $error("wait on zero count wrote the word");

  assert_wait_empty_flags_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == OP_WAIT && old_word == '0) |=> rsp_fail)
    else $error("wait on zero count not flagged");
endmodule

// File: tb/test_atomic_sync_unit.sv
module test_atomic_sync_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NR  = 4;
  localparam int NW  = 8;
  localparam int DW  = 16;
  localparam int AW  = 3;
  localparam int NV  = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0]    req_valid;
  logic [NR*3-1:0]  req_op;
  logic [NR*AW-1:0] req_addr;
  logic [NR*DW-1:0] req_data;
  logic [NR-1:0]    req_grant;
  logic [NR-1:0]    rsp_valid;
  logic [DW-1:0]    rsp_old;
  logic             rsp_fail;

  logic [2:0]    b_op   [NR];
  logic [AW-1:0] b_addr [NR];
  logic [DW-1:0] b_data [NR];

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      req_op[i*3 +: 3]    = b_op[i];
      req_addr[i*AW +: AW] = b_addr[i];
      req_data[i*DW +: DW] = b_data[i];
    end
  end

  atomic_sync_unit #(.NUM_REQ(NR), .NUM_WORDS(NW), .DATA_W(DW)) i_atomic_sync_unit (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_op (req_op), .req_addr (req_addr), .req_data (req_data),
    .req_grant (req_grant), .rsp_valid (rsp_valid), .rsp_old (rsp_old), .rsp_fail (rsp_fail)
  );

  // fields: req[40:39] op[38:36] addr[35:33] data[32:17] exp_old[16:1] exp_fail[0]
  localparam logic [40:0] VECS [NV] = '{
    {2'd0, 3'd0, 3'd0, 16'd0,      16'd0,      1'b0},  // R2 load of reset word
    {2'd1, 3'd1, 3'd0, 16'd5,      16'd0,      1'b0},  // R3 store
    {2'd2, 3'd0, 3'd0, 16'd0,      16'd5,      1'b0},  // R3 store visible
    {2'd3, 3'd2, 3'd1, 16'd0,      16'd0,      1'b0},  // R4 acquire free lock
    {2'd0, 3'd2, 3'd1, 16'd0,      16'd1,      1'b0},  // R4 busy lock
    {2'd1, 3'd0, 3'd1, 16'd0,      16'd1,      1'b0},  // R4 stays 1
    {2'd2, 3'd1, 3'd1, 16'd0,      16'd1,      1'b0},  // R3 release
    {2'd3, 3'd2, 3'd1, 16'd0,      16'd0,      1'b0},  // R4 reacquire
    {2'd0, 3'd1, 3'd2, 16'd2,      16'd0,      1'b0},  // semaphore N=2
    {2'd1, 3'd4, 3'd2, 16'd0,      16'd2,      1'b0},  // R7 take
    {2'd2, 3'd4, 3'd2, 16'd0,      16'd1,      1'b0},  // R7 take last
    {2'd3, 3'd4, 3'd2, 16'd0,      16'd0,      1'b1},  // R7 empty fails
    {2'd0, 3'd0, 3'd2, 16'd0,      16'd0,      1'b0},  // R7 count unchanged
    {2'd1, 3'd5, 3'd2, 16'd0,      16'd0,      1'b0},  // R8 signal
    {2'd2, 3'd4, 3'd2, 16'd0,      16'd1,      1'b0},  // R7 take again
    {2'd3, 3'd3, 3'd3, 16'd7,      16'd0,      1'b0},  // R6 add
    {2'd0, 3'd3, 3'd3, 16'hFFFF,   16'd7,      1'b0},  // R6 add -1
    {2'd1, 3'd0, 3'd3, 16'd0,      16'd6,      1'b0},  // R6 result
    {2'd2, 3'd1, 3'd4, 16'hFFFF,   16'd0,      1'b0},  // R3 store max
    {2'd3, 3'd3, 3'd4, 16'd2,      16'hFFFF,   1'b0},  // R6 wrap
    {2'd0, 3'd0, 3'd4, 16'd0,      16'd1,      1'b0},  // R6 wrapped to 1
    {2'd1, 3'd7, 3'd4, 16'd9,      16'd1,      1'b0},  // R11 unused opcode
    {2'd2, 3'd0, 3'd4, 16'd0,      16'd1,      1'b0},  // R11 word untouched
    {2'd3, 3'd5, 3'd7, 16'd0,      16'd0,      1'b0},  // R8 top address
    {2'd0, 3'd0, 3'd7, 16'd0,      16'd1,      1'b0}   // R8 result
  };

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_reqs();
    req_valid = '0;
    for (int i = 0; i < NR; i++) begin
      b_op[i] = 3'd0; b_addr[i] = '0; b_data[i] = '0;
    end
  endtask

  // drive one request, wait for grant, return the response
  task automatic run_op(input int r, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] old,
                        output logic fl, output logic got_rsp);
    int n;
    @(negedge clk);
    b_op[r] = op; b_addr[r] = a; b_data[r] = d; req_valid[r] = 1'b1;
    #1;
    n = 0;
    while (!req_grant[r] && n < 50) begin
      @(negedge clk); #1; n++;
    end
    @(negedge clk);
    req_valid[r] = 1'b0;
    #1;
    got_rsp = (rsp_valid == (NR'(1) << r));
    old = rsp_old;
    fl = rsp_fail;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] old;
    logic fl, got;
    logic [DW-1:0] o1, o3;
    clear_reqs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    req_valid = 4'b1111;
    #1;
    check(req_grant == '0, "R10", "no grant in reset", req_grant, 0);
    check(rsp_valid == '0, "R10", "no response in reset", rsp_valid, 0);
    req_valid = '0;
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [40:0] e;
      e = VECS[v];
      run_op(int'(e[40:39]), e[38:36], e[35:33], e[32:17], old, fl, got);
      check(got, "R1", $sformatf("vec %0d response strobe", v), longint'(got), 1);
      check(old == e[16:1], op_tag(e[38:36]), $sformatf("vec %0d old value", v), old, e[16:1]);
      check(fl == e[0], op_tag(e[38:36]), $sformatf("vec %0d fail flag", v), fl, e[0]);
    end

    // R9: last winner was requester 0, so order is 1,2,3,0
    @(negedge clk);
    req_valid = 4'b1111;
    for (int k = 0; k < NR; k++) begin
      int expw;
      expw = (k + 1) % NR;
      #1;
      check(req_grant == (NR'(1) << expw), "R9", $sformatf("rotation step %0d", k),
            req_grant, NR'(1) << expw);
      @(negedge clk);
      req_valid[expw] = 1'b0;
      #1;
      check(rsp_valid == (NR'(1) << expw), "R1", "response follows grant",
            rsp_valid, NR'(1) << expw);
    end
    req_valid = '0;

    // R10: reset clears words
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rsp_valid == '0, "R10", "no response after reset", rsp_valid, 0);
    run_op(2, 3'd0, 3'd1, 16'd0, old, fl, got);
    check(old == 16'd0, "R10", "lock word cleared", old, 0);

    // R5: simultaneous test-and-set on free word 5 from requesters 1 and 3
    @(negedge clk);
    b_op[1] = 3'd2; b_addr[1] = 3'd5; b_op[3] = 3'd2; b_addr[3] = 3'd5;
    req_valid = 4'b1010;
    #1;
    check($countones(req_grant) == 1, "R1", "single grant in contention",
          $countones(req_grant), 1);
    @(negedge clk);
    #1;
    if (rsp_valid[1]) begin o1 = rsp_old; req_valid[1] = 1'b0; end
    else begin o3 = rsp_old; req_valid[3] = 1'b0; end
    @(negedge clk);
    #1;
    if (rsp_valid[1]) begin o1 = rsp_old; req_valid[1] = 1'b0; end
    else begin o3 = rsp_old; req_valid[3] = 1'b0; end
    check((o1 + o3 == 16'd1) && (o1 <= 16'd1), "R5", "exactly one winner",
          {o1, o3}, 0);
    req_valid = '0;

    // plain load race: both see the lock free (not atomic)
    @(negedge clk);
    b_op[0] = 3'd0; b_addr[0] = 3'd6; b_op[2] = 3'd0; b_addr[2] = 3'd6;
    req_valid = 4'b0101;
    @(negedge clk); #1;
    o1 = rsp_old;
    @(negedge clk); #1;
    o3 = rsp_old;
    req_valid = '0;
    check(o1 == 0 && o3 == 0, "R2", "loads both read free", {o1, o3}, 0);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule